// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller and keeps a record of every memory request that has been sent downstream but not yet completed. Requests fall into a read class and a write class, and each class has its own small fully associative table keyed by cache-line address. A line can be in flight only once: a second request touching a line that already has an entry in either table is refused as aliased, and a request is refused as full when the tracker is at its configured limit or the target table has no free slot. Accepted requests are forwarded on a one-cycle-delayed issue channel.

Completions come back on separate read and write inputs carrying a line number. The matching entry is freed and the number of clock cycles it was outstanding is reported one cycle later. A completion that finds no entry sets a sticky protocol-error flag. Four counters record how many cycles a request was refused for each aliasing kind, and an age watchdog, armed by an insertion and re-run every threshold period while anything is outstanding, sets a sticky deadlock flag when it finds an entry at least a threshold number of cycles old.

Top module: `ort_tracker`

## Requirements
- R1: A presented request is refused with `rej_full` (and `req_ready` low) when `inflight` is at or above `MAX_OUT`, or when its own class table holds `DEPTH` entries; the full check takes priority over the alias check, and a full refusal records nothing and changes no counter.
- R2: Kind code 0 (load) and 1 (instruction fetch) are read class; every other 4-bit kind code (2 store, 3 and 4 read-modify-write halves, 5 load-linked, 6 store-conditional, 7 and 8 locked read-modify-write halves, 9 flush) is write class.
- R3: A write-class request whose line is present in either table is refused with `rej_alias`.
- R4: A read-class request whose line is present in either table is refused with `rej_alias`.
- R5: Each cycle with `rej_alias` increments exactly one counter: write class hitting the read table `cnt_st_ld`, otherwise write class `cnt_st_st`; read class hitting the write table `cnt_ld_st`, otherwise read class `cnt_ld_ld`.
- R6: Lookups use the line number, the address with its low `LINE_OFF` bits (6 by default) dropped; completion inputs carry line numbers directly.
- R7: An accepted request (`req_valid` and `req_ready`) appears on `iss_valid`, `iss_addr` and `iss_kind` in the following cycle.
- R8: A completion that matches an entry frees it and raises `rd_done_valid` or `wr_done_valid` in the following cycle with a latency equal to the number of clock edges from the accepting edge to the completing edge.
- R9: `deadlock` is sticky and becomes set within two threshold periods after any entry reaches an age of `THRESH` cycles; it never sets while every entry is younger than `THRESH`.
- R10: `inflight` always equals the number of valid entries across both tables.
- R11: A read or write completion with no matching entry in its own table sets the sticky `proto_err` output.
- R12: Lookups in a cycle see the tables before that cycle's completions, so a request to a line completing in the same cycle is refused as aliased, and an acceptance coinciding with a completion leaves `inflight` unchanged.
- R13: After reset all tables are empty, `inflight`, all counters, `iss_valid`, the done flags, `deadlock` and `proto_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_addr | input | ADDR_W | Byte address of the request |
| req_kind | input | 4 | Request kind code |
| req_ready | output | 1 | The presented request would be accepted |
| rej_full | output | 1 | Request refused: capacity |
| rej_alias | output | 1 | Request refused: line already in flight |
| iss_valid | output | 1 | Downstream issue strobe |
| iss_addr | output | ADDR_W | Address of the issued request |
| iss_kind | output | 4 | Kind of the issued request |
| rd_cpl_valid | input | 1 | Read-class completion |
| rd_cpl_line | input | ADDR_W-LINE_OFF | Line number of the read completion |
| wr_cpl_valid | input | 1 | Write-class completion |
| wr_cpl_line | input | ADDR_W-LINE_OFF | Line number of the write completion |
| rd_done_valid | output | 1 | Read completion matched |
| rd_done_lat | output | TS_W | Read miss latency in cycles |
| wr_done_valid | output | 1 | Write completion matched |
| wr_done_lat | output | TS_W | Write miss latency in cycles |
| inflight | output | clog2(2*DEPTH+1) | Number of outstanding entries |
| cnt_st_ld | output | CNT_W | Write refused by read entry |
| cnt_st_st | output | CNT_W | Write refused by write entry |
| cnt_ld_st | output | CNT_W | Read refused by write entry |
| cnt_ld_ld | output | CNT_W | Read refused by read entry |
| deadlock | output | 1 | Sticky stale-entry flag |
| proto_err | output | 1 | Sticky orphan-completion flag |

## Verification
A new request and a completion can land in the same cycle, both on the same line and on different lines, and that collision is where the tracker's bookkeeping is easiest to get wrong. The bench presents a load to a line while its read completion arrives, expecting an aliased refusal and a bumped load-on-load counter, then pairs a fresh acceptance with a write completion and expects the in-flight count to stay put. Read and write completions are also driven together to see both latencies reported in the same cycle.

// File: rtl/ort_pkg.sv
package ort_pkg;

  typedef enum logic [3:0] {
    K_LOAD    = 4'd0,
    K_FETCH   = 4'd1,
    K_STORE   = 4'd2,
    K_RMW_RD  = 4'd3,
    K_RMW_WR  = 4'd4,
    K_LINK_LD = 4'd5,
    K_COND_ST = 4'd6,
    K_LOCK_RD = 4'd7,
    K_LOCK_WR = 4'd8,
    K_FLUSH   = 4'd9
  } req_kind_e;

  // Only plain loads and instruction fetches live in the read-class table.
  function automatic logic is_write_class(input logic [3:0] kind);
    return !((kind == K_LOAD) || (kind == K_FETCH));
  endfunction

endpackage

// File: rtl/ort_table.sv
module ort_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int TS_W   = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LINE_W-1:0]              req_line,
  output logic                           look_hit,
  input  logic                           ins_en,
  input  logic [TS_W-1:0]                ins_ts,
  input  logic                           cpl_en,
  input  logic [LINE_W-1:0]              cpl_line,
  output logic                           cpl_hit,
  output logic [TS_W-1:0]                cpl_ts,
  output logic                           full,
  output logic [OCC_W-1:0]               occ,
  output logic [DEPTH-1:0]               ent_vld,
  output logic [DEPTH-1:0][TS_W-1:0]     ent_ts
);

  logic [DEPTH-1:0]              vld_q;
  logic [DEPTH-1:0][LINE_W-1:0]  line_q;
  logic [DEPTH-1:0][TS_W-1:0]    ts_q;
  logic [DEPTH-1:0]              lmatch;
  logic [DEPTH-1:0]              cmatch;
  logic [IDX_W-1:0]              free_idx;

  function automatic logic [IDX_W-1:0] lowest_free(input logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [OCC_W-1:0] pop(input logic [DEPTH-1:0] v);
    logic [OCC_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + OCC_W'(v[i]);
    return n;
  endfunction

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign lmatch[g] = vld_q[g] && (line_q[g] == req_line);
      assign cmatch[g] = vld_q[g] && (line_q[g] == cpl_line);
    end
  endgenerate

  always_comb begin
    cpl_ts = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cmatch[i]) cpl_ts = cpl_ts | ts_q[i];
    end
  end

  assign look_hit = |lmatch;
  assign cpl_hit  = cpl_en && (|cmatch);
  assign full     = &vld_q;
  assign free_idx = lowest_free(vld_q);
  assign occ      = pop(vld_q);
  assign ent_vld  = vld_q;
  assign ent_ts   = ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      line_q <= '0;
      ts_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_en && !full && (free_idx == IDX_W'(i))) begin
          vld_q[i]  <= 1'b1;
          line_q[i] <= req_line;
          ts_q[i]   <= ins_ts;
        end else if (cpl_en && cmatch[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  // R3 / R4: one entry per line, so a lookup never matches twice.
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lmatch));

  // R4: the parent only inserts a line that is absent here.
  assert_insert_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !look_hit);

  // R1: the parent never inserts into a table with no free slot.
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);

endmodule

// File: rtl/ort_watchdog.sv
module ort_watchdog #(
  parameter int NENT   = 8,
  parameter int TS_W   = 16,
  parameter int THRESH = 256,
  localparam int TMR_W = $clog2(THRESH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TS_W-1:0]            now,
  input  logic                       arm,
  input  logic                       busy,
  input  logic [NENT-1:0]            vld,
  input  logic [NENT-1:0][TS_W-1:0]  ts,
  output logic                       chk_fire,
  output logic                       deadlock
);

  logic             armed_q;
  logic [TMR_W-1:0] tmr_q;
  logic [NENT-1:0]  stale_v;

  function automatic logic [TS_W-1:0] age_of(input logic [TS_W-1:0] t_now,
                                             input logic [TS_W-1:0] t_iss);
    return t_now - t_iss;
  endfunction

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_age
      assign stale_v[g] = vld[g] && (age_of(now, ts[g]) >= TS_W'(THRESH));
    end
  endgenerate

  assign chk_fire = armed_q && (tmr_q == TMR_W'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      tmr_q    <= '0;
      deadlock <= 1'b0;
    end else begin
      if (!armed_q) begin
        if (arm) begin
          armed_q <= 1'b1;
          tmr_q   <= '0;
        end
      end else if (chk_fire) begin
        tmr_q   <= '0;
        armed_q <= busy || arm;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
      if (chk_fire && (|stale_v)) deadlock <= 1'b1;
    end
  end

  // R9: the flag only rises on a periodic check.
  assert_deadlock_on_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(chk_fire));

  // R9: once raised it stays raised.
  assert_deadlock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(deadlock) |-> deadlock);

endmodule

// File: rtl/ort_tracker.sv
module ort_tracker #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int DEPTH    = 4,
  parameter int MAX_OUT  = 7,
  parameter int TS_W     = 16,
  parameter int CNT_W    = 16,
  parameter int THRESH   = 256,
  localparam int LINE_W  = ADDR_W - LINE_OFF,
  localparam int CW      = $clog2(2 * DEPTH + 1),
  localparam int OCC_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_kind,
  output logic              req_ready,
  output logic              rej_full,
  output logic              rej_alias,
  output logic              iss_valid,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [3:0]        iss_kind,
  input  logic              rd_cpl_valid,
  input  logic [LINE_W-1:0] rd_cpl_line,
  input  logic              wr_cpl_valid,
  input  logic [LINE_W-1:0] wr_cpl_line,
  output logic              rd_done_valid,
  output logic [TS_W-1:0]   rd_done_lat,
  output logic              wr_done_valid,
  output logic [TS_W-1:0]   wr_done_lat,
  output logic [CW-1:0]     inflight,
  output logic [CNT_W-1:0]  cnt_st_ld,
  output logic [CNT_W-1:0]  cnt_st_st,
  output logic [CNT_W-1:0]  cnt_ld_st,
  output logic [CNT_W-1:0]  cnt_ld_ld,
  output logic              deadlock,
  output logic              proto_err
);
  import ort_pkg::*;

  localparam logic [CW-1:0] MAX_C = CW'(MAX_OUT);

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_OFF];
  endfunction

  function automatic logic [TS_W-1:0] lat_of(input logic [TS_W-1:0] t_now,
                                             input logic [TS_W-1:0] t_iss);
    return t_now - t_iss;
  endfunction

  logic [TS_W-1:0]   now_q;
  logic [LINE_W-1:0] req_line;
  logic              wcls;
  logic              rd_hit, wr_hit, rd_full, wr_full;
  logic              full_c, alias_c, accept;
  logic              rd_cpl_hit, wr_cpl_hit;
  logic [TS_W-1:0]   rd_cpl_ts, wr_cpl_ts;
  logic [OCC_W-1:0]  rd_occ, wr_occ;
  logic [DEPTH-1:0]  rd_vld, wr_vld;
  logic [DEPTH-1:0][TS_W-1:0] rd_ts, wr_ts;
  logic [2*DEPTH-1:0]         all_vld;
  logic [2*DEPTH-1:0][TS_W-1:0] all_ts;
  logic              chk_fire;
  logic [CW-1:0]     inflight_nx;

  assign req_line = line_of(req_addr);
  assign wcls     = is_write_class(req_kind);

  ort_table #(.DEPTH(DEPTH), .LINE_W(LINE_W), .TS_W(TS_W)) u_rd_tab (
    .clk(clk), .rst_n(rst_n), .req_line(req_line), .look_hit(rd_hit),
    .ins_en(accept && !wcls), .ins_ts(now_q),
    .cpl_en(rd_cpl_valid), .cpl_line(rd_cpl_line), .cpl_hit(rd_cpl_hit),
    .cpl_ts(rd_cpl_ts), .full(rd_full), .occ(rd_occ),
    .ent_vld(rd_vld), .ent_ts(rd_ts));

  ort_table #(.DEPTH(DEPTH), .LINE_W(LINE_W), .TS_W(TS_W)) u_wr_tab (
    .clk(clk), .rst_n(rst_n), .req_line(req_line), .look_hit(wr_hit),
    .ins_en(accept && wcls), .ins_ts(now_q),
    .cpl_en(wr_cpl_valid), .cpl_line(wr_cpl_line), .cpl_hit(wr_cpl_hit),
    .cpl_ts(wr_cpl_ts), .full(wr_full), .occ(wr_occ),
    .ent_vld(wr_vld), .ent_ts(wr_ts));

  assign all_vld = {wr_vld, rd_vld};
  assign all_ts  = {wr_ts, rd_ts};

  ort_watchdog #(.NENT(2 * DEPTH), .TS_W(TS_W), .THRESH(THRESH)) u_wdog (
    .clk(clk), .rst_n(rst_n), .now(now_q), .arm(accept),
    .busy(inflight != '0), .vld(all_vld), .ts(all_ts),
    .chk_fire(chk_fire), .deadlock(deadlock));

  // Capacity first, then aliasing against both tables.
  assign full_c    = (inflight >= MAX_C) || (wcls ? wr_full : rd_full);
  assign alias_c   = !full_c && (rd_hit || wr_hit);
  assign req_ready = !full_c && !alias_c;
  assign accept    = req_valid && req_ready;
  assign rej_full  = req_valid && full_c;
  assign rej_alias = req_valid && alias_c;

  assign inflight_nx = inflight + CW'(accept) - CW'(rd_cpl_hit) - CW'(wr_cpl_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q         <= '0;
      inflight      <= '0;
      iss_valid     <= 1'b0;
      iss_addr      <= '0;
      iss_kind      <= '0;
      rd_done_valid <= 1'b0;
      rd_done_lat   <= '0;
      wr_done_valid <= 1'b0;
      wr_done_lat   <= '0;
      proto_err     <= 1'b0;
      cnt_st_ld     <= '0;
      cnt_st_st     <= '0;
      cnt_ld_st     <= '0;
      cnt_ld_ld     <= '0;
    end else begin
      now_q    <= now_q + 1'b1;
      inflight <= inflight_nx;
      iss_valid <= accept;
      if (accept) begin
        iss_addr <= req_addr;
        iss_kind <= req_kind;
      end
      rd_done_valid <= rd_cpl_hit;
      wr_done_valid <= wr_cpl_hit;
      if (rd_cpl_hit) rd_done_lat <= lat_of(now_q, rd_cpl_ts);
      if (wr_cpl_hit) wr_done_lat <= lat_of(now_q, wr_cpl_ts);
      if ((rd_cpl_valid && !rd_cpl_hit) || (wr_cpl_valid && !wr_cpl_hit))
        proto_err <= 1'b1;
      if (rej_alias) begin
        if (wcls) begin
          if (rd_hit) cnt_st_ld <= cnt_st_ld + 1'b1;
          else        cnt_st_st <= cnt_st_st + 1'b1;
        end else begin
          if (wr_hit) cnt_ld_st <= cnt_ld_st + 1'b1;
          else        cnt_ld_ld <= cnt_ld_ld + 1'b1;
        end
      end
    end
  end

  // R10: the running count tracks the table occupancies.
  assert_count_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inflight == (CW'(rd_occ) + CW'(wr_occ)));

  // R1: at the limit nothing is accepted.
  assert_refuse_at_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight >= MAX_C) |-> !req_ready);

  // R7: every acceptance is followed by an issue strobe.
  assert_issue_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> iss_valid);

endmodule

// File: tb/ort_tracker_bench.sv
module ort_tracker_bench;

  localparam int ADDR_W = 32;
  localparam int LOFF   = 6;
  localparam int LW     = ADDR_W - LOFF;
  localparam int TS_W   = 16;
  localparam int THR    = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_kind = '0;
  logic req_ready, rej_full, rej_alias, iss_valid;
  logic [ADDR_W-1:0] iss_addr;
  logic [3:0] iss_kind;
  logic rd_cpl_valid = 1'b0, wr_cpl_valid = 1'b0;
  logic [LW-1:0] rd_cpl_line = '0, wr_cpl_line = '0;
  logic rd_done_valid, wr_done_valid;
  logic [TS_W-1:0] rd_done_lat, wr_done_lat;
  logic [3:0] inflight;
  logic [15:0] cnt_st_ld, cnt_st_st, cnt_ld_st, cnt_ld_ld;
  logic deadlock, proto_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ort_tracker u_ort_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_ready(req_ready), .rej_full(rej_full),
    .rej_alias(rej_alias), .iss_valid(iss_valid), .iss_addr(iss_addr),
    .iss_kind(iss_kind), .rd_cpl_valid(rd_cpl_valid), .rd_cpl_line(rd_cpl_line),
    .wr_cpl_valid(wr_cpl_valid), .wr_cpl_line(wr_cpl_line),
    .rd_done_valid(rd_done_valid), .rd_done_lat(rd_done_lat),
    .wr_done_valid(wr_done_valid), .wr_done_lat(wr_done_lat),
    .inflight(inflight), .cnt_st_ld(cnt_st_ld), .cnt_st_st(cnt_st_st),
    .cnt_ld_st(cnt_ld_st), .cnt_ld_ld(cnt_ld_ld), .deadlock(deadlock),
    .proto_err(proto_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // {kind, addr, exp_ready, exp_full, exp_alias}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {4'd0, 32'h0000_1000, 3'b100},  // load A
    {4'd2, 32'h0000_1008, 3'b001},  // store on loaded line
    {4'd0, 32'h0000_103F, 3'b001},  // load, same line via offset bits
    {4'd2, 32'h0000_2000, 3'b100},  // store B
    {4'd0, 32'h0000_2004, 3'b001},  // load on stored line
    {4'd9, 32'h0000_2010, 3'b001},  // flush on stored line
    {4'd1, 32'h0000_3000, 3'b100},  // fetch C
    {4'd5, 32'h0000_4000, 3'b100},  // load-linked D (write class)
    {4'd6, 32'h0000_5000, 3'b100},  // store-conditional E
    {4'd8, 32'h0000_6000, 3'b100},  // locked write F, write table now full
    {4'd2, 32'h0000_7000, 3'b010},  // store refused: write table full
    {4'd0, 32'h0000_8000, 3'b100},  // load H, reaches the limit of 7
    {4'd1, 32'h0000_9000, 3'b010},  // fetch refused: count limit
    {4'd0, 32'h0000_1000, 3'b010}   // full wins over alias
  };

  int acc_cyc [NV];
  int acc_x;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R13 reset state
    chk("R13 inflight", 32'(inflight), 0);
    chk("R13 iss_valid", 32'(iss_valid), 0);
    chk("R13 deadlock", 32'(deadlock), 0);
    chk("R13 proto_err", 32'(proto_err), 0);
    chk("R13 counters", 32'(cnt_st_ld | cnt_st_st | cnt_ld_st | cnt_ld_ld), 0);
    chk("R13 done", 32'({rd_done_valid, wr_done_valid}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] k;
      logic [31:0] a;
      string tag;
      k = VEC[i][38:35];
      a = VEC[i][34:3];
      if (VEC[i][1]) tag = "R1";
      else if (VEC[i][0] && a[5:0] != 0) tag = "R6";
      else if (VEC[i][0]) tag = (k > 4'd1) ? "R3" : "R4";
      else tag = (k == 4'd5 || k == 4'd6 || k == 4'd8) ? "R2" : "R7";
      req_valid = 1'b1; req_addr = a; req_kind = k;
      #1;
      chk(tag, 32'({req_ready, rej_full, rej_alias}), 32'(VEC[i][2:0]));
      step();
      req_valid = 1'b0;
      acc_cyc[i] = cyc;
      chk("R7 iss_valid", 32'(iss_valid), 32'(VEC[i][2]));
      if (VEC[i][2]) begin
        chk("R7 iss_addr", iss_addr, a);
        chk("R7 iss_kind", 32'(iss_kind), 32'(k));
      end
    end

    chk("R10 inflight after walk", 32'(inflight), 7);
    chk("R5 st_ld", 32'(cnt_st_ld), 1);
    chk("R5 st_st", 32'(cnt_st_st), 1);
    chk("R5 ld_st", 32'(cnt_ld_st), 1);
    chk("R5 ld_ld", 32'(cnt_ld_ld), 1);

    // R8 latency for line A
    repeat (3) step();
    rd_cpl_valid = 1'b1; rd_cpl_line = LW'(32'h1000 >> LOFF);
    step();
    rd_cpl_valid = 1'b0;
    chk("R8 rd_done_valid", 32'(rd_done_valid), 1);
    chk("R8 rd_done_lat", 32'(rd_done_lat), 32'(cyc - acc_cyc[0]));
    chk("R10 inflight", 32'(inflight), 6);

    // R12 request to a line completing in the same cycle
    rd_cpl_valid = 1'b1; rd_cpl_line = LW'(32'h3000 >> LOFF);
    req_valid = 1'b1; req_addr = 32'h3000; req_kind = 4'd0;
    #1;
    chk("R12 alias on completing line", 32'({req_ready, rej_alias}), 32'b01);
    step();
    rd_cpl_valid = 1'b0; req_valid = 1'b0;
    chk("R12 inflight", 32'(inflight), 5);
    chk("R5 ld_ld after R12", 32'(cnt_ld_ld), 2);

    // R12 accept and unrelated completion together
    wr_cpl_valid = 1'b1; wr_cpl_line = LW'(32'h2000 >> LOFF);
    req_valid = 1'b1; req_addr = 32'h0000_A000; req_kind = 4'd0;
    #1;
    chk("R12 accept beside completion", 32'(req_ready), 1);
    step();
    wr_cpl_valid = 1'b0; req_valid = 1'b0;
    acc_x = cyc;
    chk("R12 inflight net", 32'(inflight), 5);
    chk("R8 wr_done_valid", 32'(wr_done_valid), 1);

    // R8 read and write completions together
    step();
    rd_cpl_valid = 1'b1; rd_cpl_line = LW'(32'h8000 >> LOFF);
    wr_cpl_valid = 1'b1; wr_cpl_line = LW'(32'h4000 >> LOFF);
    step();
    rd_cpl_valid = 1'b0; wr_cpl_valid = 1'b0;
    chk("R8 both done", 32'({rd_done_valid, wr_done_valid}), 32'b11);
    chk("R8 rd lat H", 32'(rd_done_lat), 32'(cyc - acc_cyc[11]));
    chk("R8 wr lat D", 32'(wr_done_lat), 32'(cyc - acc_cyc[7]));

    wr_cpl_valid = 1'b1; wr_cpl_line = LW'(32'h5000 >> LOFF);
    step();
    wr_cpl_line = LW'(32'h6000 >> LOFF);
    rd_cpl_valid = 1'b1; rd_cpl_line = LW'(32'hA000 >> LOFF);
    step();
    rd_cpl_valid = 1'b0; wr_cpl_valid = 1'b0;
    chk("R8 rd lat X", 32'(rd_done_lat), 32'(cyc - acc_x));
    chk("R10 drained", 32'(inflight), 0);
    chk("R11 no error yet", 32'(proto_err), 0);

    // R11 orphan completion
    wr_cpl_valid = 1'b1; wr_cpl_line = LW'(32'h1000 >> LOFF);
    step();
    wr_cpl_valid = 1'b0;
    chk("R11 proto_err", 32'(proto_err), 1);
    chk("R11 no done", 32'(wr_done_valid), 0);
    step();
    chk("R11 sticky", 32'(proto_err), 1);

    // R9 watchdog
    chk("R9 quiet so far", 32'(deadlock), 0);
    req_valid = 1'b1; req_addr = 32'h0000_B000; req_kind = 4'd0;
    step();
    req_valid = 1'b0;
    repeat (THR - 2) step();
    chk("R9 not before threshold", 32'(deadlock), 0);
    repeat (2 * THR) step();
    chk("R9 stale entry flagged", 32'(deadlock), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule